// File: doc/BRIEF.md
# Per-Cycle Test Vector Pin Checker

This block runs a stream of test vectors against a group of device pins. Each vector covers one tester cycle. For every pin it carries a 3-bit symbol that does one of three things: it drives the pin to a level, it states the level the pin should present, or it leaves the pin alone. Vectors arrive on a valid/ready handshake and are applied in the order they arrive. When the next vector is already waiting, cycles run back to back.

Each pin has two digital flags from an external window comparator: one says the pin is above the high threshold, the other says it is below the low threshold. At a programmable tick late in each cycle, the block samples these flags and judges every compared pin. It then reports a per-pin fail mask together with the index of the vector, qualified by a one-clock valid pulse. A sticky flag records that at least one failure has occurred, and it stays set until software-free logic upstream clears it with a clear strobe.

The tester cycle is a run of clock ticks. Its length and the strobe tick are configuration inputs and are held steady while vectors run. The strobe tick is smaller than the length, and the length is at least 1.

The cycle controller has two states, IDLE and RUN, with these transitions:

- IDLE→RUN: a vector is accepted while idle.
- RUN→RUN (restart): the last tick ends and the next vector is accepted in the same clock.
- RUN→RUN (count): a tick that is not the last simply advances the tick counter.
- RUN→IDLE (release): the last tick ends and no vector is waiting. All pin drivers are released.

Top module: `vector_pin_checker`

## Requirements
- R1: Pin symbol code 0 or 1 sets that pin's drive-enable to 1 and its drive-data to 0 or 1. The outputs take effect from the first tick of the vector's cycle, and the pin is never marked as failing.
- R2: Symbol code 2 expects low and fails unless the below-low flag is set. Code 3 expects high and fails unless the above-high flag is set. Code 4 expects high impedance and fails if either flag is set. For all three codes, drive-enable is 0.
- R3: Symbol code 7 (ignore) and the reserved codes 5 and 6 neither drive nor compare. Drive-enable is 0 and the pin's fail bit is 0 whatever the flags are.
- R4: The flags are sampled at the clock edge that ends tick `strobe_at` of a cycle. `res_valid` is high for exactly the one clock after that edge, carrying the fail mask. Counting the accept edge as edge 0, that edge is `strobe_at`+1 clock edges after acceptance.
- R5: `res_index` gives the zero-based position of the vector in the stream since reset. Each accepted vector increments it by one.
- R6: `vec_ready` is high while idle and during the last tick of a cycle. A vector accepted in the last tick starts its own cycle on the very next tick, and vectors are applied in order.
- R7: `sticky_fail` is set by any result with a non-zero fail mask and is cleared by `sticky_clr`. If a failing result and a clear land on the same edge, the failure wins and the flag stays set.
- R8: After reset, `vec_ready` is 1, and drive-enable, `res_valid`, the fail mask, `res_index` and `sticky_fail` are all 0. When a cycle ends with no vector waiting, every drive-enable returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vec_valid | input | 1 | Vector offered |
| vec_ready | output | 1 | Vector can be taken this clock |
| vec_data | input | 3*NPINS | Per-pin symbols, pin k in bits [3k+2:3k] |
| cyc_len | input | CNT_W | Ticks per tester cycle (at least 1) |
| strobe_at | input | CNT_W | Tick at which flags are judged (below cyc_len) |
| above_voh | input | NPINS | Per-pin above-high comparator flag |
| below_vol | input | NPINS | Per-pin below-low comparator flag |
| sticky_clr | input | 1 | Clear the sticky fail flag |
| drv_en | output | NPINS | Per-pin drive enable |
| drv_data | output | NPINS | Per-pin drive level |
| res_valid | output | 1 | One-clock result qualifier |
| res_fail | output | NPINS | Per-pin fail mask of the judged cycle |
| res_index | output | IDX_W | Stream position of the judged vector |
| sticky_fail | output | 1 | Accumulated fail flag |

## Verification
Two functions can land in the same clock edge: a failing strobe recording into the sticky flag, and an external clear of that same flag. The bench raises `sticky_clr` during exactly the strobe tick of a vector whose pins are made to fail. It expects the flag to remain set afterwards. It then repeats the collision with a passing vector and expects the flag to drop. A back-to-back pair of vectors also makes the handshake for one vector coincide with the last tick of the previous cycle. That case is judged by the drive outputs changing on the next tick and by consecutive result indices.

// File: rtl/vpc_pkg.sv
package vpc_pkg;

    localparam logic [2:0] SYM_DRV0   = 3'd0;
    localparam logic [2:0] SYM_DRV1   = 3'd1;
    localparam logic [2:0] SYM_EXP_LO = 3'd2;
    localparam logic [2:0] SYM_EXP_HI = 3'd3;
    localparam logic [2:0] SYM_EXP_HZ = 3'd4;
    localparam logic [2:0] SYM_IGNORE = 3'd7;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } cyc_state_t;

endpackage

// File: rtl/vpc_pin_judge.sv
module vpc_pin_judge
    import vpc_pkg::*;
(
    input  logic [2:0] sym,
    input  logic       above,
    input  logic       below,
    output logic       drv_en,
    output logic       drv_val,
    output logic       mismatch
);

    always_comb begin
        drv_en   = 1'b0;
        drv_val  = 1'b0;
        mismatch = 1'b0;
        unique case (sym)
            SYM_DRV0: begin
                drv_en = 1'b1;
            end
            SYM_DRV1: begin
                drv_en  = 1'b1;
                drv_val = 1'b1;
            end
            SYM_EXP_LO: mismatch = ~below;
            SYM_EXP_HI: mismatch = ~above;
            SYM_EXP_HZ: mismatch = above | below;
            default: ;  // ignore and reserved codes
        endcase
    end

endmodule

// File: rtl/vpc_cycle_fsm.sv
module vpc_cycle_fsm
    import vpc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vec_valid,
    input  logic [CNT_W-1:0] cyc_len,
    input  logic [CNT_W-1:0] strobe_at,
    output logic             vec_ready,
    output logic             take,
    output logic             strobe,
    output logic             release_pins
);

    cyc_state_t       state_q, state_d;
    logic [CNT_W-1:0] tick_q, tick_d;
    logic             last_tick;

    assign last_tick = (tick_q == cyc_len - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            tick_q  <= '0;
        end else begin
            state_q <= state_d;
            tick_q  <= tick_d;
        end
    end

    always_comb begin
        state_d      = state_q;
        tick_d       = tick_q;
        vec_ready    = 1'b0;
        take         = 1'b0;
        strobe       = 1'b0;
        release_pins = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                vec_ready = 1'b1;
                take      = vec_valid;
                if (vec_valid) begin
                    state_d = ST_RUN;
                    tick_d  = '0;
                end
            end
            ST_RUN: begin
                strobe = (tick_q == strobe_at);
                if (last_tick) begin
                    vec_ready = 1'b1;
                    take      = vec_valid;
                    tick_d    = '0;
                    if (!vec_valid) begin
                        state_d      = ST_IDLE;
                        release_pins = 1'b1;
                    end
                end else begin
                    tick_d = tick_q + 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/vector_pin_checker.sv
module vector_pin_checker
    import vpc_pkg::*;
#(
    parameter int NPINS = 4,
    parameter int CNT_W = 8,
    parameter int IDX_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               vec_valid,
    output logic               vec_ready,
    input  logic [3*NPINS-1:0] vec_data,
    input  logic [CNT_W-1:0]   cyc_len,
    input  logic [CNT_W-1:0]   strobe_at,
    input  logic [NPINS-1:0]   above_voh,
    input  logic [NPINS-1:0]   below_vol,
    input  logic               sticky_clr,
    output logic [NPINS-1:0]   drv_en,
    output logic [NPINS-1:0]   drv_data,
    output logic               res_valid,
    output logic [NPINS-1:0]   res_fail,
    output logic [IDX_W-1:0]   res_index,
    output logic               sticky_fail
);

    localparam int VEC_W = 3 * NPINS;

    logic             take, strobe, release_pins;
    logic [VEC_W-1:0] vec_q;
    logic [IDX_W-1:0] next_idx_q, cur_idx_q;
    logic [NPINS-1:0] miss;

    vpc_cycle_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .vec_valid    (vec_valid),
        .cyc_len      (cyc_len),
        .strobe_at    (strobe_at),
        .vec_ready    (vec_ready),
        .take         (take),
        .strobe       (strobe),
        .release_pins (release_pins)
    );

    genvar p;
    generate
        for (p = 0; p < NPINS; p++) begin : g_pin
            vpc_pin_judge u_judge (
                .sym      (vec_q[3*p +: 3]),
                .above    (above_voh[p]),
                .below    (below_vol[p]),
                .drv_en   (drv_en[p]),
                .drv_val  (drv_data[p]),
                .mismatch (miss[p])
            );
        end
    endgenerate

    // Active vector: all-ignore when no cycle is running
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_q      <= '1;
            next_idx_q <= '0;
            cur_idx_q  <= '0;
        end else if (take) begin
            vec_q      <= vec_data;
            cur_idx_q  <= next_idx_q;
            next_idx_q <= next_idx_q + 1'b1;
        end else if (release_pins) begin
            vec_q <= '1;
        end
    end

    // Result capture at the strobe tick; a failure outranks a clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid   <= 1'b0;
            res_fail    <= '0;
            res_index   <= '0;
            sticky_fail <= 1'b0;
        end else begin
            res_valid <= strobe;
            if (strobe) begin
                res_fail  <= miss;
                res_index <= cur_idx_q;
            end
            if (strobe && (|miss))
                sticky_fail <= 1'b1;
            else if (sticky_clr)
                sticky_fail <= 1'b0;
        end
    end

endmodule

// File: rtl/vector_pin_checker_chk.sv
module vector_pin_checker_chk #(
    parameter int NPINS = 4,
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             vec_ready,
    input logic [CNT_W-1:0] cyc_len,
    input logic [NPINS-1:0] drv_en,
    input logic             res_valid,
    input logic [NPINS-1:0] res_fail,
    input logic             sticky_fail,
    input logic             sticky_clr
);

    // R7
    fail_sets_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && (res_fail != '0)) |-> sticky_fail);

    // R7
    sticky_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky_fail && !sticky_clr) |=> sticky_fail);

    // R4
    result_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && (cyc_len > 1)) |=> !res_valid);

    // R6
    drive_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(drv_en) |-> $past(vec_ready));

endmodule

bind vector_pin_checker vector_pin_checker_chk #(.NPINS(NPINS), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .vec_ready   (vec_ready),
    .cyc_len     (cyc_len),
    .drv_en      (drv_en),
    .res_valid   (res_valid),
    .res_fail    (res_fail),
    .sticky_fail (sticky_fail),
    .sticky_clr  (sticky_clr)
);

// File: tb/vector_pin_checker_test.sv
module vector_pin_checker_test;

    localparam int NP = 4;
    localparam int NT = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          vec_valid = 1'b0;
    logic          vec_ready;
    logic [11:0]   vec_data = '1;
    logic [7:0]    cyc_len = 8'd4;
    logic [7:0]    strobe_at = 8'd2;
    logic [NP-1:0] above_voh = '0;
    logic [NP-1:0] below_vol = '0;
    logic          sticky_clr = 1'b0;
    logic [NP-1:0] drv_en, drv_data, res_fail;
    logic          res_valid, sticky_fail;
    logic [15:0]   res_index;

    int checks = 0;
    int fails = 0;
    int idx = 0;

    always #2 clk = ~clk;

    vector_pin_checker uut (
        .clk(clk), .rst_n(rst_n), .vec_valid(vec_valid), .vec_ready(vec_ready),
        .vec_data(vec_data), .cyc_len(cyc_len), .strobe_at(strobe_at),
        .above_voh(above_voh), .below_vol(below_vol), .sticky_clr(sticky_clr),
        .drv_en(drv_en), .drv_data(drv_data), .res_valid(res_valid),
        .res_fail(res_fail), .res_index(res_index), .sticky_fail(sticky_fail)
    );

    // vec, above, below, fail mask, drive enable, drive data (pin0 = low bits)
    typedef struct packed {
        logic [11:0] vec;
        logic [3:0]  ab;
        logic [3:0]  bl;
        logic [3:0]  mask;
        logic [3:0]  en;
        logic [3:0]  dat;
    } row_t;

    localparam row_t TABLE [NT] = '{
        '{ {3'd7,3'd4,3'd3,3'd2}, 4'b0010, 4'b0001, 4'b0000, 4'b0000, 4'b0000 },
        '{ {3'd7,3'd4,3'd3,3'd2}, 4'b0000, 4'b0000, 4'b0011, 4'b0000, 4'b0000 },
        '{ {3'd1,3'd0,3'd1,3'd0}, 4'b1111, 4'b1111, 4'b0000, 4'b1111, 4'b1010 },
        '{ {3'd4,3'd4,3'd4,3'd4}, 4'b0100, 4'b0001, 4'b0101, 4'b0000, 4'b0000 },
        '{ {3'd6,3'd5,3'd6,3'd5}, 4'b1111, 4'b1111, 4'b0000, 4'b0000, 4'b0000 },
        '{ {3'd3,3'd2,3'd0,3'd7}, 4'b0000, 4'b1000, 4'b1100, 4'b0010, 4'b0000 }
    };

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Runs one isolated vector from idle; returns at the negedge after release.
    task automatic run_vec(input row_t r, input logic clr_at_strobe, input logic exp_sticky);
        @(negedge clk);
        vec_data  = r.vec;
        above_voh = r.ab;
        below_vol = r.bl;
        vec_valid = 1'b1;
        chk(vec_ready == 1'b1, "R6 ready idle", int'(vec_ready), 1);
        @(negedge clk);                       // tick 0
        vec_valid = 1'b0;
        chk(drv_en == r.en, "R1/R2/R3 drv_en", int'(drv_en), int'(r.en));
        chk(drv_data == r.dat, "R1 drv_data", int'(drv_data), int'(r.dat));
        @(negedge clk);                       // tick 1
        @(negedge clk);                       // tick 2 (strobe)
        sticky_clr = clr_at_strobe;
        chk(res_valid == 1'b0, "R4 early", int'(res_valid), 0);
        @(negedge clk);                       // tick 3: result visible
        sticky_clr = 1'b0;
        chk(res_valid == 1'b1, "R4 valid", int'(res_valid), 1);
        chk(res_fail == r.mask, "R2/R3 mask", int'(res_fail), int'(r.mask));
        chk(res_index == 16'(idx), "R5 index", int'(res_index), idx);
        chk(sticky_fail == exp_sticky, "R7 sticky", int'(sticky_fail), int'(exp_sticky));
        idx++;
        @(negedge clk);                       // released, idle
        chk(res_valid == 1'b0, "R4 pulse", int'(res_valid), 0);
        chk(drv_en == '0, "R8 release", int'(drv_en), 0);
    endtask

    initial begin
        #(4 * 100000);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic stk;
        repeat (3) @(negedge clk);
        // R8 reset state
        chk(vec_ready == 1'b1, "R8 ready", int'(vec_ready), 1);
        chk(drv_en == '0, "R8 drv_en", int'(drv_en), 0);
        chk(res_valid == 1'b0 && res_fail == '0, "R8 result", int'(res_fail), 0);
        chk(res_index == '0 && sticky_fail == 1'b0, "R8 idx/sticky", int'(sticky_fail), 0);
        rst_n = 1'b1;

        stk = 1'b0;
        for (int i = 0; i < NT; i++) begin
            if (TABLE[i].mask != '0) stk = 1'b1;
            run_vec(TABLE[i], 1'b0, stk);
        end

        // R7 clear alone
        @(negedge clk);
        sticky_clr = 1'b1;
        @(negedge clk);
        sticky_clr = 1'b0;
        chk(sticky_fail == 1'b0, "R7 clear", int'(sticky_fail), 0);

        // R7 failing strobe and clear on the same edge: failure wins
        run_vec(TABLE[1], 1'b1, 1'b1);
        // R7 passing strobe with clear: flag drops
        run_vec(TABLE[0], 1'b1, 1'b0);

        // R6 back-to-back: second vector waits for the last tick
        @(negedge clk);
        vec_data = TABLE[2].vec; above_voh = '1; below_vol = '1; vec_valid = 1'b1;
        @(negedge clk);                       // V1 tick 0
        vec_data = TABLE[5].vec;
        chk(vec_ready == 1'b0, "R6 busy", int'(vec_ready), 0);
        chk(drv_en == 4'b1111, "R1 first drive", int'(drv_en), 15);
        @(negedge clk); @(negedge clk);       // ticks 1, 2
        above_voh = 4'b0000; below_vol = 4'b0100;
        @(negedge clk);                       // tick 3: result of V1, ready
        chk(vec_ready == 1'b1, "R6 last tick ready", int'(vec_ready), 1);
        chk(res_index == 16'(idx), "R5 first index", int'(res_index), idx);
        idx++;
        @(negedge clk);                       // V2 tick 0
        vec_valid = 1'b0;
        chk(drv_en == 4'b0010 && drv_data == 4'b0000, "R6 next drive", int'(drv_en), 2);
        @(negedge clk); @(negedge clk); @(negedge clk);
        chk(res_valid == 1'b1 && res_fail == 4'b1000, "R6 second mask", int'(res_fail), 8);
        chk(res_index == 16'(idx), "R5 second index", int'(res_index), idx);
        @(negedge clk);
        chk(drv_en == '0, "R8 release after pair", int'(drv_en), 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule